// File: doc/BRIEF.md
# Flow-Control Link Training Sequencer and Detector

This block handles link training on a seven-bit flow-control path. The path carries a start-of-frame bit, a four-bit data nibble, a parity bit and a ready bit. Each clock carries one phase of the path. On the transmit side a one-cycle start request begins a training burst. A burst is a pair of fixed ten-phase halves, sent as many times as the repeat count on `tx_alpha` asks. While no burst is running, the transmit pins carry the normal flow-control word given on the `tx_norm_*` inputs.

The receive side watches the incoming word for the first-half training code. When that code arrives on three samples in a row, the block raises a one-cycle deskew request. The request goes to whatever alignment logic sits beyond this block. An ignore flag stops the request. The match counter saturates, so a long run of training words yields a single request.

Top module: `fc_train_unit`

## Requirements
- R1: After reset `tx_busy` and `rx_deskew_req` are 0 and the transmit pins carry the normal input word.
- R2: While `tx_busy` is 0 the transmit outputs equal `tx_norm_sof`, `tx_norm_dat`, `tx_norm_par` and `tx_norm_rdy` combinationally.
- R3: A `tx_start` sampled high while idle, with `tx_alpha` nonzero, makes `tx_busy` 1 from the next cycle with the first training phase on the pins. A start with `tx_alpha` equal to 0 is ignored.
- R4: The first ten phases of each pair drive sof=1, dat=4'hC (binary 1100, bit 3 first), par=0 and rdy=0.
- R5: The second ten phases of each pair drive sof=0, dat=4'h3, par=1 and rdy=1.
- R6: A burst lasts exactly 20 times the latched repeat count in cycles. Then `tx_busy` returns to 0 and the pass-through of R2 resumes.
- R7: During a burst a new `tx_start`, or a change of `tx_alpha`, has no effect on the pattern or on its length.
- R8: When the receive inputs show sof=1, dat=4'hC, par=0 and rdy=0 at three consecutive clock edges, `rx_deskew_req` is 1 for the one cycle after the third edge.
- R9: A sample that differs from that code in any single field (sof, any data bit, par or rdy) restarts the count of consecutive matches.
- R10: A run of matching samples longer than three produces only one request. A new request needs a non-matching sample first.
- R11: When `rx_ignore` is 1 at the edge that samples the third match, no request is raised, and none follows later in that same run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one phase per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_start | input | 1 | One-cycle request to begin a training burst |
| tx_alpha | input | ALPHA_W | Number of 20-phase pairs in a burst |
| tx_norm_sof | input | 1 | Normal start-of-frame value when idle |
| tx_norm_dat | input | 4 | Normal data nibble when idle |
| tx_norm_par | input | 1 | Normal parity value when idle |
| tx_norm_rdy | input | 1 | Normal ready value when idle |
| tx_sof | output | 1 | Transmit start-of-frame pin |
| tx_dat | output | 4 | Transmit data nibble |
| tx_par | output | 1 | Transmit parity pin |
| tx_rdy | output | 1 | Transmit ready pin |
| tx_busy | output | 1 | High while a training burst is on the pins |
| rx_sof | input | 1 | Received start-of-frame bit |
| rx_dat | input | 4 | Received data nibble |
| rx_par | input | 1 | Received parity bit |
| rx_rdy | input | 1 | Received ready bit |
| rx_ignore | input | 1 | Suppresses deskew requests when 1 |
| rx_deskew_req | output | 1 | One-cycle training-detected pulse |

## Verification
Some receive cases are hard to reach from the ports. One is a run of matches that is cut short by a word wrong in exactly one field. Another is a run that outlasts three samples while the ignore flag changes partway through. The stimulus reaches these cases with a sweep. It covers run lengths 0 to 5, each of the four fields as the breaking field, and both ignore settings, and it adds a run where the ignore flag clears after the third match. On the transmit side, a start is re-issued and the repeat count is changed in the middle of a burst. The bench then checks that the length still follows the count latched at the start.

// File: rtl/fct_pkg.sv
package fct_pkg;

    localparam int DAT_W = 4;

    typedef struct packed {
        logic             sof;
        logic [DAT_W-1:0] dat;
        logic             par;
        logic             rdy;
    } fc_word_t;

    localparam fc_word_t TRAIN_HI = '{sof: 1'b1, dat: 4'hC, par: 1'b0, rdy: 1'b0};
    localparam fc_word_t TRAIN_LO = '{sof: 1'b0, dat: 4'h3, par: 1'b1, rdy: 1'b1};

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/fct_tx_seq.sv
module fct_tx_seq
    import fct_pkg::*;
#(
    parameter int ALPHA_W  = 8,
    parameter int HALF_LEN = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [ALPHA_W-1:0] alpha_i,
    output logic               busy_o,
    output logic               second_half_o
);

    localparam int PH_W = (HALF_LEN > 1) ? $clog2(HALF_LEN) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF_LEN - 1);

    typedef struct packed {
        seq_state_e         state;
        logic [PH_W-1:0]    phase;
        logic               half;
        logic [ALPHA_W-1:0] reps;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            SEQ_IDLE: begin
                if (start_i && (alpha_i != '0)) begin
                    seq_d.state = SEQ_RUN;
                    seq_d.phase = '0;
                    seq_d.half  = 1'b0;
                    seq_d.reps  = alpha_i;
                end
            end
            SEQ_RUN: begin
                if (seq_q.phase == PH_LAST) begin
                    seq_d.phase = '0;
                    if (seq_q.half) begin
                        seq_d.half = 1'b0;
                        if (seq_q.reps == ALPHA_W'(1)) begin
                            seq_d.state = SEQ_IDLE;
                            seq_d.reps  = '0;
                        end else begin
                            seq_d.reps = seq_q.reps - ALPHA_W'(1);
                        end
                    end else begin
                        seq_d.half = 1'b1;
                    end
                end else begin
                    seq_d.phase = seq_q.phase + PH_W'(1);
                end
            end
            default: seq_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: SEQ_IDLE, phase: '0, half: 1'b0, reps: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o        = (seq_q.state == SEQ_RUN);
    assign second_half_o = seq_q.half;

endmodule

// File: rtl/fct_tx_mux.sv
module fct_tx_mux
    import fct_pkg::*;
(
    input  logic     busy_i,
    input  logic     second_half_i,
    input  fc_word_t norm_i,
    output fc_word_t word_o
);

    fc_word_t train_w;

    always_comb begin
        train_w = second_half_i ? TRAIN_LO : TRAIN_HI;
        word_o  = busy_i ? train_w : norm_i;
    end

endmodule

// File: rtl/fct_rx_detect.sv
module fct_rx_detect
    import fct_pkg::*;
#(
    parameter int RUN_LEN = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  fc_word_t word_i,
    input  logic     ignore_i,
    output logic     pulse_o
);

    localparam int CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);
    localparam logic [CNT_W-1:0] CNT_PRE = CNT_W'(RUN_LEN - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } det_t;

    det_t det_d, det_q;
    logic hit;

    always_comb begin
        hit   = (word_i == TRAIN_HI);
        det_d = det_q;
        det_d.pulse = 1'b0;
        if (!hit) begin
            det_d.cnt = '0;
        end else begin
            if (det_q.cnt != CNT_MAX) begin
                det_d.cnt = det_q.cnt + CNT_W'(1);
            end
            if ((det_q.cnt == CNT_PRE) && !ignore_i) begin
                det_d.pulse = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q <= '{cnt: '0, pulse: 1'b0};
        end else begin
            det_q <= det_d;
        end
    end

    assign pulse_o = det_q.pulse;

endmodule

// File: rtl/fc_train_unit.sv
module fc_train_unit
    import fct_pkg::*;
#(
    parameter int ALPHA_W  = 8,
    parameter int HALF_LEN = 10,
    parameter int RUN_LEN  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_start,
    input  logic [ALPHA_W-1:0] tx_alpha,
    input  logic               tx_norm_sof,
    input  logic [3:0]         tx_norm_dat,
    input  logic               tx_norm_par,
    input  logic               tx_norm_rdy,
    output logic               tx_sof,
    output logic [3:0]         tx_dat,
    output logic               tx_par,
    output logic               tx_rdy,
    output logic               tx_busy,
    input  logic               rx_sof,
    input  logic [3:0]         rx_dat,
    input  logic               rx_par,
    input  logic               rx_rdy,
    input  logic               rx_ignore,
    output logic               rx_deskew_req
);

    logic     seq_busy;
    logic     seq_half;
    fc_word_t norm_w;
    fc_word_t out_w;
    fc_word_t rx_w;

    assign norm_w = '{sof: tx_norm_sof, dat: tx_norm_dat, par: tx_norm_par, rdy: tx_norm_rdy};
    assign rx_w   = '{sof: rx_sof, dat: rx_dat, par: rx_par, rdy: rx_rdy};

    fct_tx_seq #(
        .ALPHA_W  (ALPHA_W),
        .HALF_LEN (HALF_LEN)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (tx_start),
        .alpha_i       (tx_alpha),
        .busy_o        (seq_busy),
        .second_half_o (seq_half)
    );

    fct_tx_mux u_mux (
        .busy_i        (seq_busy),
        .second_half_i (seq_half),
        .norm_i        (norm_w),
        .word_o        (out_w)
    );

    fct_rx_detect #(
        .RUN_LEN (RUN_LEN)
    ) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_i   (rx_w),
        .ignore_i (rx_ignore),
        .pulse_o  (rx_deskew_req)
    );

    assign tx_sof  = out_w.sof;
    assign tx_dat  = out_w.dat;
    assign tx_par  = out_w.par;
    assign tx_rdy  = out_w.rdy;
    assign tx_busy = seq_busy;

endmodule

// File: rtl/fct_checker.sv
module fct_checker #(
    parameter int ALPHA_W  = 8,
    parameter int HALF_LEN = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tx_start,
    input logic [ALPHA_W-1:0] tx_alpha,
    input logic               tx_norm_sof,
    input logic [3:0]         tx_norm_dat,
    input logic               tx_norm_par,
    input logic               tx_norm_rdy,
    input logic               tx_sof,
    input logic [3:0]         tx_dat,
    input logic               tx_par,
    input logic               tx_rdy,
    input logic               tx_busy,
    input logic               rx_sof,
    input logic [3:0]         rx_dat,
    input logic               rx_par,
    input logic               rx_rdy,
    input logic               rx_ignore,
    input logic               rx_deskew_req
);

    localparam int PAIR = 2 * HALF_LEN;

    logic [6:0]  txw, normw;
    logic        rx_hit;
    logic [31:0] run_len_q;

    assign txw    = {tx_sof, tx_dat, tx_par, tx_rdy};
    assign normw  = {tx_norm_sof, tx_norm_dat, tx_norm_par, tx_norm_rdy};
    assign rx_hit = rx_sof && (rx_dat == 4'hC) && !rx_par && !rx_rdy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       run_len_q <= '0;
        else if (tx_busy) run_len_q <= run_len_q + 32'd1;
        else              run_len_q <= '0;
    end

    a_r2_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> (txw == normw));

    a_r3_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && tx_start && (tx_alpha != '0)) |=> tx_busy);

    a_r4_r5_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |-> ((txw == 7'b1_1100_00) || (txw == 7'b0_0011_11)));

    a_r6_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_busy) |-> ((run_len_q % PAIR) == 0) && (run_len_q != 0));

    a_r8_three_hits: assert property (@(posedge clk) disable iff (!rst_n)
        rx_deskew_req |-> ($past(rx_hit, 1) && $past(rx_hit, 2) && $past(rx_hit, 3)));

    a_r10_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_deskew_req |=> !rx_deskew_req);

    a_r11_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        rx_deskew_req |-> !$past(rx_ignore));

endmodule

bind fc_train_unit fct_checker #(
    .ALPHA_W  (ALPHA_W),
    .HALF_LEN (HALF_LEN)
) u_fct_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_start      (tx_start),
    .tx_alpha      (tx_alpha),
    .tx_norm_sof   (tx_norm_sof),
    .tx_norm_dat   (tx_norm_dat),
    .tx_norm_par   (tx_norm_par),
    .tx_norm_rdy   (tx_norm_rdy),
    .tx_sof        (tx_sof),
    .tx_dat        (tx_dat),
    .tx_par        (tx_par),
    .tx_rdy        (tx_rdy),
    .tx_busy       (tx_busy),
    .rx_sof        (rx_sof),
    .rx_dat        (rx_dat),
    .rx_par        (rx_par),
    .rx_rdy        (rx_rdy),
    .rx_ignore     (rx_ignore),
    .rx_deskew_req (rx_deskew_req)
);

// File: tb/fc_train_unit_test.sv
`timescale 1ns/1ps
module fc_train_unit_test;

    localparam int ALPHA_W = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               tx_start = 1'b0;
    logic [ALPHA_W-1:0] tx_alpha = '0;
    logic               tx_norm_sof = 1'b0;
    logic [3:0]         tx_norm_dat = 4'h0;
    logic               tx_norm_par = 1'b0;
    logic               tx_norm_rdy = 1'b0;
    logic               tx_sof, tx_par, tx_rdy, tx_busy;
    logic [3:0]         tx_dat;
    logic               rx_sof = 1'b0;
    logic [3:0]         rx_dat = 4'h0;
    logic               rx_par = 1'b0;
    logic               rx_rdy = 1'b0;
    logic               rx_ignore = 1'b0;
    logic               rx_deskew_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int run = 0;

    always #2 clk = ~clk;

    fc_train_unit #(.ALPHA_W(ALPHA_W)) uut (
        .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_alpha(tx_alpha),
        .tx_norm_sof(tx_norm_sof), .tx_norm_dat(tx_norm_dat),
        .tx_norm_par(tx_norm_par), .tx_norm_rdy(tx_norm_rdy),
        .tx_sof(tx_sof), .tx_dat(tx_dat), .tx_par(tx_par), .tx_rdy(tx_rdy),
        .tx_busy(tx_busy), .rx_sof(rx_sof), .rx_dat(rx_dat), .rx_par(rx_par),
        .rx_rdy(rx_rdy), .rx_ignore(rx_ignore), .rx_deskew_req(rx_deskew_req)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] tx_word();
        return {1'b0, tx_sof, tx_dat, tx_par, tx_rdy};
    endfunction

    function automatic logic [7:0] norm_word();
        return {1'b0, tx_norm_sof, tx_norm_dat, tx_norm_par, tx_norm_rdy};
    endfunction

    task automatic rand_norm();
        {tx_norm_sof, tx_norm_dat, tx_norm_par, tx_norm_rdy} = 7'($urandom);
    endtask

    // Burst of 'alpha' pairs; optional restart and alpha change mid-burst.
    task automatic run_burst(input int alpha, input bit disturb);
        @(negedge clk);
        tx_alpha = ALPHA_W'(alpha);
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        for (int k = 0; k < 20 * alpha; k++) begin
            logic [7:0] exp;
            rand_norm();
            #0.1;
            exp = (((k / 10) % 2) == 0) ? 8'b0_1_1100_00 : 8'b0_0_0011_11;
            check("R3", {7'd0, tx_busy}, 8'd1);
            check(((k / 10) % 2) == 0 ? "R4" : "R5", tx_word(), exp);
            if (disturb && k == 5) begin
                tx_start = 1'b1;
                tx_alpha = ALPHA_W'(alpha + 3);
            end else begin
                tx_start = 1'b0;
            end
            if (disturb && k == 6) check("R7", {7'd0, tx_busy}, 8'd1);
            @(negedge clk);
        end
        tx_start = 1'b0;
        rand_norm();
        #0.1;
        check("R6", {7'd0, tx_busy}, 8'd0);
        check("R6", tx_word(), norm_word());
        if (disturb) begin
            @(negedge clk);
            check("R7", {7'd0, tx_busy}, 8'd0);
        end
    endtask

    // Drive one receive word, then compare the pulse one edge later.
    task automatic rx_step(input logic [6:0] w, input bit ign, input string req);
        bit exp;
        rx_ignore = ign;
        {rx_sof, rx_dat, rx_par, rx_rdy} = w;
        if (w == 7'b1_1100_00) run++; else run = 0;
        exp = (run == 3) && !ign;
        @(negedge clk);
        check(req, {7'd0, rx_deskew_req}, {7'd0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rand_norm();
        #1;
        // R1: reset state
        check("R1", {7'd0, tx_busy}, 8'd0);
        check("R1", {7'd0, rx_deskew_req}, 8'd0);
        check("R1", tx_word(), norm_word());
        #10 rst_n = 1'b1;
        @(negedge clk);

        // R2: pass-through sweep while idle
        for (int v = 0; v < 128; v++) begin
            {tx_norm_sof, tx_norm_dat, tx_norm_par, tx_norm_rdy} = 7'(v);
            #0.5;
            check("R2", tx_word(), norm_word());
        end

        // R3: zero alpha start is ignored
        @(negedge clk);
        tx_alpha = '0;
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        check("R3", {7'd0, tx_busy}, 8'd0);
        check("R3", tx_word(), norm_word());

        // R4 R5 R6: bursts of 1..4 pairs
        for (int a = 1; a <= 4; a++) run_burst(a, 1'b0);
        // R7: restart and alpha change mid-burst
        run_burst(2, 1'b1);

        // R8 R9 R10 R11: receive sweep
        @(negedge clk);
        for (int ign = 0; ign < 2; ign++) begin
            for (int len = 0; len <= 5; len++) begin
                for (int f = 0; f < 4; f++) begin
                    logic [6:0] miss;
                    miss = 7'b1_1100_00;
                    case (f)
                        0: miss[6] = 1'b0;
                        1: miss[2 + (len % 4)] = ~miss[2 + (len % 4)];
                        2: miss[1] = 1'b1;
                        default: miss[0] = 1'b1;
                    endcase
                    for (int i = 0; i < len; i++)
                        rx_step(7'b1_1100_00, ign[0], len > 3 ? "R10" : (ign != 0 ? "R11" : "R8"));
                    rx_step(miss, ign[0], "R9");
                end
            end
        end
        // R11: ignore clears after third match, no late pulse
        rx_step(7'b1_1100_00, 1'b1, "R11");
        rx_step(7'b1_1100_00, 1'b1, "R11");
        rx_step(7'b1_1100_00, 1'b1, "R11");
        rx_step(7'b1_1100_00, 1'b0, "R11");
        rx_step(7'b1_1100_00, 1'b0, "R11");
        rx_step(7'b0_0011_11, 1'b0, "R9");
        // R8: fresh run after break
        for (int i = 0; i < 4; i++) rx_step(7'b1_1100_00, 1'b0, "R8");
        rx_step(7'b0_0000_00, 1'b0, "R9");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule